// File: doc/BRIEF.md
# Programmable Almost-Full/Almost-Empty Flag Unit

This unit sits beside a FIFO's storage and pointer logic. It keeps two threshold offsets: an empty offset n and a full offset m. From the FIFO's current word count and its fixed capacity it produces two registered, active-low warning flags. The almost-empty flag is low while fewer than n words are stored. The almost-full flag is low while more than capacity minus m words are stored.

A master reset loads a default pair of offsets. The level of the load input during that reset chooses 127 or 1023 for both offsets, and it also fixes the loading method for later use. In parallel mode each enabled write with the load input high takes an offset from the data bus. In serial mode each enabled serial strobe shifts in one bit. With the load input high, a read returns the offsets on the data outputs. While the load input is high, the write and read enables forwarded to the FIFO's data pointers are held off. A partial reset clears the load and read-back sequencing but keeps the offsets and the chosen method.

All controls are sampled on a single clock. The word count arrives already in this clock domain.

Top module: `pafe_unit`

## Requirements
- R1: On a clock edge with `mrst_i` high, both offsets become 127 and parallel mode is chosen if `ld_i` is 0. Both offsets become 1023 and serial mode is chosen if `ld_i` is 1. Either way the load and read-back sequencing returns to the empty offset.
- R2: `pae_n_o` is registered. One clock edge after `count_i` is presented it is 0 when `count_i` < n and 1 otherwise.
- R3: `paf_n_o` is registered. One clock edge after `count_i` is presented it is 0 when `count_i` > CAP − m and 1 otherwise. CAP is 16384 by default.
- R4: In parallel mode, each edge with `ld_i` and `wen_i` high (and neither reset) writes `din_i[13:0]` into the next offset. The offsets alternate empty, full, empty, and so on.
- R5: Each edge with `ld_i` and `ren_i` high (and neither reset) makes `rd_vld_o` 1 on the next cycle. `rd_data_o` then holds the next offset, zero-extended, alternating empty then full. `rd_vld_o` is 0 after any other edge.
- R6: In serial mode, each edge with `sen_i` high stores `si_i` as the next bit. Bits fill the empty offset LSB first and then the full offset LSB first. After 28 bits further serial bits are ignored.
- R7: Serial strobes have no effect on the offsets in parallel mode. Writes with `ld_i` high have no effect on the offsets in serial mode.
- R8: On an edge with `prst_i` high (and `mrst_i` low), the offsets and the mode are kept. Parallel loading, read-back and serial bit position restart at the empty offset.
- R9: `fifo_wr_en_o` equals `wen_i` and `fifo_rd_en_o` equals `ren_i` while `ld_i` is 0. Both are 0 while `ld_i` is 1.
- R10: After the asynchronous reset `rst_n`, `pae_n_o` is 0, `paf_n_o` is 1, `rd_vld_o` is 0, both offsets are 127, and parallel mode is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mrst_i | input | 1 | Master reset: loads defaults and samples the method from `ld_i` |
| prst_i | input | 1 | Partial reset: restarts sequencing and keeps the offsets |
| ld_i | input | 1 | Selects offset access instead of FIFO data access |
| wen_i | input | 1 | Write enable |
| ren_i | input | 1 | Read enable |
| sen_i | input | 1 | Serial bit strobe |
| si_i | input | 1 | Serial offset bit |
| din_i | input | 18 | Data bus carrying parallel offsets |
| count_i | input | 15 | Current FIFO word count |
| pae_n_o | output | 1 | Almost-empty flag, active low |
| paf_n_o | output | 1 | Almost-full flag, active low |
| rd_vld_o | output | 1 | Read-back word valid |
| rd_data_o | output | 18 | Read-back offset, zero-extended |
| fifo_wr_en_o | output | 1 | Write enable forwarded to the FIFO pointers |
| fifo_rd_en_o | output | 1 | Read enable forwarded to the FIFO pointers |

## Verification
The flags are tried with counts set one below, at and one above each threshold, under both default pairs and under offsets loaded in parallel and serially. This separates a strict compare from an inclusive one and an offset that is wrong from a method that is wrong. Read-back runs of two and three words tell a toggling pointer from a stuck one. Serial runs of 28 bits followed by extra ones show the bit order and the stop after the last bit. Mixed stimulus applies serial strobes in parallel mode, parallel writes in serial mode, and a partial reset after an odd number of accesses. Together these separate ignored stimulus from retained state and show that sequencing restarts after the partial reset.

// File: rtl/pafe_pkg.sv
package pafe_pkg;
  typedef enum logic {PRG_PAR = 1'b0, PRG_SER = 1'b1} prg_mode_e;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;
endpackage

// File: rtl/pafe_ofs_regs.sv
module pafe_ofs_regs
  import pafe_pkg::*;
#(
  parameter int DW     = 18,
  parameter int OFS_W  = 14,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023,
  localparam int SER_BITS = 2 * OFS_W,
  localparam int SC_W     = $clog2(SER_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrst_i,
  input  logic             prst_i,
  input  logic             ld_i,
  input  logic             wen_i,
  input  logic             sen_i,
  input  logic             si_i,
  input  logic [DW-1:0]    din_i,
  output logic [OFS_W-1:0] ofs_n_o,
  output logic [OFS_W-1:0] ofs_m_o,
  output prg_mode_e        mode_o,
  output logic [SC_W-1:0]  ser_cnt_o
);
  localparam logic [OFS_W-1:0] DEF_LO_V = OFS_W'(DEF_LO);
  localparam logic [OFS_W-1:0] DEF_HI_V = OFS_W'(DEF_HI);
  localparam logic [SC_W-1:0]  SER_END  = SC_W'(SER_BITS);

  logic [OFS_W-1:0] n_q, n_d, m_q, m_d;
  prg_mode_e        mode_q, mode_d;
  ofs_sel_e         wsel_q, wsel_d;
  logic [SC_W-1:0]  sc_q, sc_d;

  always_comb begin
    n_d    = n_q;
    m_d    = m_q;
    mode_d = mode_q;
    wsel_d = wsel_q;
    sc_d   = sc_q;
    if (mrst_i) begin
      mode_d = ld_i ? PRG_SER : PRG_PAR;
      n_d    = ld_i ? DEF_HI_V : DEF_LO_V;
      m_d    = ld_i ? DEF_HI_V : DEF_LO_V;
      wsel_d = SEL_EMPTY;
      sc_d   = '0;
    end else if (prst_i) begin
      wsel_d = SEL_EMPTY;
      sc_d   = '0;
    end else begin
      if (mode_q == PRG_PAR && ld_i && wen_i) begin
        if (wsel_q == SEL_EMPTY) n_d = din_i[OFS_W-1:0];
        else                     m_d = din_i[OFS_W-1:0];
        wsel_d = (wsel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
      end
      if (mode_q == PRG_SER && sen_i && sc_q < SER_END) begin
        for (int b = 0; b < OFS_W; b++) begin
          if (sc_q == SC_W'(b))         n_d[b] = si_i;
          if (sc_q == SC_W'(b + OFS_W)) m_d[b] = si_i;
        end
        sc_d = sc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= DEF_LO_V;
      m_q    <= DEF_LO_V;
      mode_q <= PRG_PAR;
      wsel_q <= SEL_EMPTY;
      sc_q   <= '0;
    end else begin
      n_q    <= n_d;
      m_q    <= m_d;
      mode_q <= mode_d;
      wsel_q <= wsel_d;
      sc_q   <= sc_d;
    end
  end

  assign ofs_n_o   = n_q;
  assign ofs_m_o   = m_q;
  assign mode_o    = mode_q;
  assign ser_cnt_o = sc_q;
endmodule

// File: rtl/pafe_readback.sv
module pafe_readback
  import pafe_pkg::*;
#(
  parameter int DW    = 18,
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrst_i,
  input  logic             prst_i,
  input  logic             ld_i,
  input  logic             ren_i,
  input  logic [OFS_W-1:0] ofs_n_i,
  input  logic [OFS_W-1:0] ofs_m_i,
  output logic             rd_vld_o,
  output logic [DW-1:0]    rd_data_o
);
  ofs_sel_e      rsel_q, rsel_d;
  logic          vld_q, vld_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    rsel_d = rsel_q;
    vld_d  = 1'b0;
    data_d = data_q;
    if (mrst_i || prst_i) begin
      rsel_d = SEL_EMPTY;
    end else if (ld_i && ren_i) begin
      vld_d  = 1'b1;
      data_d = '0;
      data_d[OFS_W-1:0] = (rsel_q == SEL_EMPTY) ? ofs_n_i : ofs_m_i;
      rsel_d = (rsel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= SEL_EMPTY;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      rsel_q <= rsel_d;
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign rd_vld_o  = vld_q;
  assign rd_data_o = data_q;
endmodule

// File: rtl/pafe_flag_cmp.sv
module pafe_flag_cmp #(
  parameter int CAP   = 16384,
  parameter int CNT_W = 15,
  parameter int OFS_W = 14,
  localparam int SUM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [OFS_W-1:0] ofs_n_i,
  input  logic [OFS_W-1:0] ofs_m_i,
  output logic             pae_n_o,
  output logic             paf_n_o
);
  localparam logic [SUM_W-1:0] CAP_V = SUM_W'(CAP);

  logic [SUM_W-1:0] cnt_x, n_x, m_x;
  logic pae_q, pae_d, paf_q, paf_d;

  always_comb begin
    cnt_x = SUM_W'(count_i);
    n_x   = SUM_W'(ofs_n_i);
    m_x   = SUM_W'(ofs_m_i);
    pae_d = !(cnt_x < n_x);
    paf_d = !((cnt_x + m_x) > CAP_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pae_q <= 1'b0;
      paf_q <= 1'b1;
    end else begin
      pae_q <= pae_d;
      paf_q <= paf_d;
    end
  end

  assign pae_n_o = pae_q;
  assign paf_n_o = paf_q;
endmodule

// File: rtl/pafe_unit.sv
module pafe_unit
  import pafe_pkg::*;
#(
  parameter int DW     = 18,
  parameter int CAP    = 16384,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023,
  localparam int OFS_W = $clog2(CAP),
  localparam int CNT_W = OFS_W + 1,
  localparam int SC_W  = $clog2(2 * OFS_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrst_i,
  input  logic             prst_i,
  input  logic             ld_i,
  input  logic             wen_i,
  input  logic             ren_i,
  input  logic             sen_i,
  input  logic             si_i,
  input  logic [DW-1:0]    din_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             pae_n_o,
  output logic             paf_n_o,
  output logic             rd_vld_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             fifo_wr_en_o,
  output logic             fifo_rd_en_o
);
  logic [OFS_W-1:0] ofs_n, ofs_m;
  prg_mode_e        mode;
  logic [SC_W-1:0]  ser_cnt;

  pafe_ofs_regs #(.DW(DW), .OFS_W(OFS_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_regs (
    .clk(clk), .rst_n(rst_n), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
    .wen_i(wen_i), .sen_i(sen_i), .si_i(si_i), .din_i(din_i),
    .ofs_n_o(ofs_n), .ofs_m_o(ofs_m), .mode_o(mode), .ser_cnt_o(ser_cnt)
  );

  pafe_readback #(.DW(DW), .OFS_W(OFS_W)) u_rdbk (
    .clk(clk), .rst_n(rst_n), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
    .ren_i(ren_i), .ofs_n_i(ofs_n), .ofs_m_i(ofs_m),
    .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o)
  );

  pafe_flag_cmp #(.CAP(CAP), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .ofs_n_i(ofs_n), .ofs_m_i(ofs_m),
    .pae_n_o(pae_n_o), .paf_n_o(paf_n_o)
  );

  assign fifo_wr_en_o = wen_i & ~ld_i;
  assign fifo_rd_en_o = ren_i & ~ld_i;
endmodule

// File: rtl/pafe_unit_chk.sv
module pafe_unit_chk #(
  parameter int OFS_W  = 14,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023,
  parameter int SC_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrst_i,
  input logic             prst_i,
  input logic             ld_i,
  input logic             wen_i,
  input logic             ren_i,
  input logic             sen_i,
  input logic             rd_vld_o,
  input logic             fifo_wr_en_o,
  input logic             fifo_rd_en_o,
  input logic [OFS_W-1:0] ofs_n,
  input logic [OFS_W-1:0] ofs_m,
  input logic             ser_mode,
  input logic [SC_W-1:0]  ser_cnt
);
  AST_MRST_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst_i && !ld_i) |=> (ofs_n == OFS_W'(DEF_LO) && ofs_m == OFS_W'(DEF_LO) && !ser_mode)); // R1
  AST_MRST_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst_i && ld_i) |=> (ofs_n == OFS_W'(DEF_HI) && ofs_m == OFS_W'(DEF_HI) && ser_mode)); // R1
  AST_RD_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && ren_i && !mrst_i && !prst_i) |=> rd_vld_o); // R5
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_i && ren_i) |=> !rd_vld_o); // R5
  AST_SER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ser_cnt <= SC_W'(2 * OFS_W)); // R6
  AST_SER_NO_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst_i && !prst_i && ser_mode && !sen_i) |=> ($stable(ofs_n) && $stable(ofs_m))); // R7
  AST_PAR_NO_SER: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrst_i && !prst_i && !ser_mode && !(ld_i && wen_i)) |=> ($stable(ofs_n) && $stable(ofs_m))); // R7
  AST_PRST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (prst_i && !mrst_i) |=> ($stable(ofs_n) && $stable(ofs_m) && $stable(ser_mode))); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |-> (!fifo_wr_en_o && !fifo_rd_en_o)); // R9
  AST_PTR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |-> (fifo_wr_en_o == wen_i && fifo_rd_en_o == ren_i)); // R9
endmodule

bind pafe_unit pafe_unit_chk #(.OFS_W(OFS_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI), .SC_W(SC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
  .wen_i(wen_i), .ren_i(ren_i), .sen_i(sen_i), .rd_vld_o(rd_vld_o),
  .fifo_wr_en_o(fifo_wr_en_o), .fifo_rd_en_o(fifo_rd_en_o),
  .ofs_n(ofs_n), .ofs_m(ofs_m), .ser_mode(mode), .ser_cnt(ser_cnt)
);

// File: tb/test_pafe_unit.sv
`timescale 1ns/1ps
module test_pafe_unit;
  localparam int DW = 18, CAP = 16384, OFS_W = 14, CNT_W = 15;

  logic clk = 1'b0;
  logic rst_n, mrst_i, prst_i, ld_i, wen_i, ren_i, sen_i, si_i;
  logic [DW-1:0] din_i;
  logic [CNT_W-1:0] count_i;
  logic pae_n_o, paf_n_o, rd_vld_o, fifo_wr_en_o, fifo_rd_en_o;
  logic [DW-1:0] rd_data_o;

  always #2.5 clk = ~clk;

  pafe_unit i_pafe_unit (
    .clk(clk), .rst_n(rst_n), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
    .wen_i(wen_i), .ren_i(ren_i), .sen_i(sen_i), .si_i(si_i), .din_i(din_i),
    .count_i(count_i), .pae_n_o(pae_n_o), .paf_n_o(paf_n_o), .rd_vld_o(rd_vld_o),
    .rd_data_o(rd_data_o), .fifo_wr_en_o(fifo_wr_en_o), .fifo_rd_en_o(fifo_rd_en_o)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;
  int exp_n, exp_m, scnt;
  bit ser_mode, wsel, rsel;
  int exp_q[$];

  task automatic check(string req, int act, int expv);
    vectors++;
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Scoreboard monitor: pops the expected offset for every read-back word
  always @(negedge clk) begin
    if (rst_n && rd_vld_o) begin
      if (exp_q.size() == 0) check("R5 unexpected word", int'(rd_data_o), -1);
      else check("R5 read-back", int'(rd_data_o), exp_q.pop_front());
    end
  end

  task automatic idle();
    @(negedge clk);
    mrst_i = 0; prst_i = 0; ld_i = 0; wen_i = 0; ren_i = 0; sen_i = 0; si_i = 0;
  endtask

  task automatic do_mrst(bit l);
    @(negedge clk); mrst_i = 1; ld_i = l;
    exp_n = l ? 1023 : 127; exp_m = exp_n; ser_mode = l;
    wsel = 0; rsel = 0; scnt = 0;
    idle();
  endtask

  task automatic do_prst();
    @(negedge clk); prst_i = 1;
    wsel = 0; rsel = 0; scnt = 0;
    idle();
  endtask

  task automatic par_write(int v);
    @(negedge clk); ld_i = 1; wen_i = 1; din_i = DW'(v);
    #1 check("R9 write held while loading", int'(fifo_wr_en_o), 0);
    if (!ser_mode) begin
      if (!wsel) exp_n = v; else exp_m = v;
      wsel = !wsel;
    end
    idle();
  endtask

  task automatic rd_back();
    @(negedge clk); ld_i = 1; ren_i = 1;
    #1 check("R9 read held while loading", int'(fifo_rd_en_o), 0);
    exp_q.push_back(rsel ? exp_m : exp_n);
    rsel = !rsel;
    idle();
  endtask

  task automatic ser_bit(bit b);
    @(negedge clk); sen_i = 1; si_i = b;
    if (ser_mode && scnt < 2*OFS_W) begin
      if (scnt < OFS_W) exp_n[scnt] = b; else exp_m[scnt-OFS_W] = b;
      scnt++;
    end
  endtask

  task automatic ser_word(int v);
    for (int b = 0; b < OFS_W; b++) ser_bit(v[b]);
    idle();
  endtask

  task automatic flags(int c, string req);
    @(negedge clk); count_i = CNT_W'(c);
    @(negedge clk);
    if (req == "R2") check("R2 almost-empty", int'(pae_n_o), (c < exp_n) ? 0 : 1);
    else             check("R3 almost-full",  int'(paf_n_o), (c + exp_m > CAP) ? 0 : 1);
  endtask

  initial begin
    rst_n = 0; mrst_i = 0; prst_i = 0; ld_i = 0; wen_i = 0; ren_i = 0;
    sen_i = 0; si_i = 0; din_i = '0; count_i = '0;
    exp_n = 127; exp_m = 127; ser_mode = 0; wsel = 0; rsel = 0; scnt = 0;
    #12;
    check("R10 pae_n reset", int'(pae_n_o), 0);
    check("R10 paf_n reset", int'(paf_n_o), 1);
    check("R10 rd_vld reset", int'(rd_vld_o), 0);
    @(negedge clk); rst_n = 1;
    rd_back(); rd_back();                               // R10 defaults 127
    flags(126, "R2"); flags(127, "R2");
    flags(CAP-127, "R3"); flags(CAP-126, "R3");
    // R1 master reset, parallel default
    do_mrst(0);
    par_write(10); par_write(20);                       // R4
    flags(9, "R2"); flags(10, "R2");
    flags(CAP-20, "R3"); flags(CAP-19, "R3");
    rd_back(); rd_back(); rd_back();                    // R5 10,20,10
    // R9 pass-through when not loading
    @(negedge clk); wen_i = 1; ren_i = 1;
    #1 check("R9 write passes", int'(fifo_wr_en_o), 1);
    check("R9 read passes", int'(fifo_rd_en_o), 1);
    idle();
    // R7 serial strobes ignored in parallel mode
    ser_word(16'h3FFF);
    rd_back();                                          // rsel was at full
    rd_back();
    // R8 partial reset after an odd number of accesses
    par_write(33); rd_back();
    do_prst();
    par_write(44); rd_back(); rd_back();                // expect 44, 20
    flags(43, "R2"); flags(44, "R2");
    // R1 master reset, serial default 1023
    do_mrst(1);
    flags(1022, "R2"); flags(1023, "R2");
    flags(CAP-1023, "R3"); flags(CAP-1022, "R3");
    rd_back(); rd_back();
    // R6 serial load n=5, m=9, then extra ones ignored
    ser_word(5); ser_word(9);
    for (int k = 0; k < 3; k++) ser_bit(1'b1);
    idle();
    rd_back(); rd_back();
    flags(4, "R2"); flags(5, "R2"); flags(CAP-9, "R3"); flags(CAP-8, "R3");
    // R7 parallel writes ignored in serial mode
    par_write(77); par_write(88);
    rd_back(); rd_back();
    // R8 partial reset keeps serial mode, restarts bit position
    do_prst();
    ser_word(6); ser_word(7);
    rd_back(); rd_back();
    flags(5, "R2"); flags(6, "R2");
    repeat (3) @(negedge clk);
    check("R5 all read-back words seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule